// File: doc/BRIEF.md
# Multi-Waveform Lookup Signal Generator

This block drives a periodic 8-bit unsigned sample stream into an external parallel 8-bit digital-to-analog converter. A free-running 6-bit phase counter steps once per clock through 64 positions. Each position addresses a sample table that holds one period of four shapes: sine, triangle, square and sawtooth. A 2-bit select input picks the shape that reaches the output.

The table address and the select value are captured in registers on the clock edge. The shape sample is then looked up from those registered values, so each sample lags the phase counter by one clock. All table contents are computed inside the design by constant functions, so no memory image has to be loaded. Changing the shape select does not disturb the phase. Only the synchronous reset returns the waveform to its first entry.

Top module: `sig_gen_top`

## Requirements
- R1: The phase counter is 6 bits wide, advances by one on every rising clock edge without reset, and wraps from 63 to 0, so the output repeats exactly every 64 clocks.
- R2: The table address register loads the phase counter value on each edge, so the sample presented after edge e (counting from the first edge with reset low) is entry (e-1) mod 64. Entry 0 is therefore shown after the reset edges and after the first edge that follows release.
- R3: With select 2'b00 (sine), entry n equals round(127.5 + 127.5*sin(2*pi*n/64)), with halves rounded up. Entry 0 is 128, entry 16 is 255, entry 32 is 128 and entry 48 is 0.
- R4: With select 2'b01 (triangle), entry n equals 8*n for n in 0..31 and 8*(63-n) for n in 32..63. It peaks at 248 on entries 31 and 32.
- R5: With select 2'b10 (square), entry n equals 255 for n in 0..31 and 0 for n in 32..63.
- R6: With select 2'b11 (sawtooth), entry n equals 4*n, which runs from 0 to 252.
- R7: The select is registered together with the address. A new select value applies to the sample presented after the next rising edge, and a select change leaves the phase sequence unbroken.
- R8: Reset is synchronous and active high. A rising edge with reset high clears the phase counter and the address register to 0. The output then shows entry 0 of the shape that was selected at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_sel | input | 2 | Shape select: 00 sine, 01 triangle, 10 square, 11 sawtooth |
| sample | output | 8 | Unsigned sample to the converter |

## Verification
A reset edge and a shape change can land on the same clock edge. In that cycle the phase restarts and the shape switches together. The bench provokes this by raising reset in the same cycle that it moves the select to a new value. It then expects entry 0 of the new shape, followed by the restarted sequence of that shape. A second case changes the select on every clock during a long sweep. Each sample is judged against the shape selected one edge earlier, at a phase that has kept counting.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    localparam int PHASE_W    = 6;
    localparam int SAMPLE_W   = 8;
    localparam int SEL_W      = 2;
    localparam int NUM_SHAPES = 1 << SEL_W;
    localparam int DEPTH      = 1 << PHASE_W;
    localparam int HALF       = DEPTH / 2;
    localparam int QUARTER    = DEPTH / 4;
    localparam int FULL_SCALE = (1 << SAMPLE_W) - 1;

    typedef logic [PHASE_W-1:0]  phase_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [SEL_W-1:0] {
        SHAPE_SINE   = 2'b00,
        SHAPE_TRI    = 2'b01,
        SHAPE_SQUARE = 2'b10,
        SHAPE_SAW    = 2'b11
    } shape_e;

    // Rising quarter of the sine, positions 0..QUARTER, already rounded.
    function automatic int sine_quarter(input int k);
        case (k)
            0:  return 128;
            1:  return 140;
            2:  return 152;
            3:  return 165;
            4:  return 176;
            5:  return 188;
            6:  return 198;
            7:  return 208;
            8:  return 218;
            9:  return 226;
            10: return 234;
            11: return 240;
            12: return 245;
            13: return 250;
            14: return 253;
            15: return 254;
            default: return 255;
        endcase
    endfunction

    // Positive half of the sine, positions 0..HALF-1, mirrored about the peak.
    function automatic int sine_upper(input int m);
        if (m <= QUARTER) return sine_quarter(m);
        return sine_quarter(HALF - m);
    endfunction

    function automatic sample_t sine_at(input phase_t n);
        int idx;
        idx = int'(n);
        if (idx < HALF) return sample_t'(sine_upper(idx));
        if (idx == HALF) return sample_t'(128);
        return sample_t'(FULL_SCALE - sine_upper(idx - HALF));
    endfunction

    function automatic sample_t tri_at(input phase_t n);
        int idx;
        idx = int'(n);
        if (idx < HALF) return sample_t'(idx * 8);
        return sample_t'((DEPTH - 1 - idx) * 8);
    endfunction

    function automatic sample_t square_at(input phase_t n);
        return (int'(n) < HALF) ? sample_t'(FULL_SCALE) : sample_t'(0);
    endfunction

    function automatic sample_t saw_at(input phase_t n);
        return sample_t'(int'(n) * 4);
    endfunction

    function automatic sample_t shape_sample(input shape_e s, input phase_t n);
        case (s)
            SHAPE_SINE:   return sine_at(n);
            SHAPE_TRI:    return tri_at(n);
            SHAPE_SQUARE: return square_at(n);
            default:      return saw_at(n);
        endcase
    endfunction

endpackage

// File: rtl/wg_phase_counter.sv
module wg_phase_counter
    import wavegen_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_o
);

    typedef struct packed {
        logic [PW-1:0] phase;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R1: from the terminal count, the next value is zero
    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_o == {PW{1'b1}}) |=> (phase_o == '0));

    // R1: a non-terminal count is followed by a strictly larger one
    assert_phase_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_o != {PW{1'b1}}) |=> (phase_o > $past(phase_o)));

endmodule

// File: rtl/wg_wave_table.sv
module wg_wave_table
    import wavegen_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int NS = NUM_SHAPES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase_i,
    input  shape_e        sel_i,
    output sample_t       sample_o
);

    typedef struct packed {
        logic [PW-1:0] addr;
        shape_e        sel;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    sample_t    lane [NS];

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_i;
        if (rst) begin
            st_d.addr = '0;
        end else begin
            st_d.addr = phase_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar s = 0; s < NS; s++) begin : g_lane
        assign lane[s] = shape_sample(shape_e'(s), phase_t'(st_q.addr));
    end

    assign sample_o = lane[st_q.sel];

    // R2: the address in use is the phase seen one edge before
    assert_addr_lag_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.addr == $past(phase_i)));

    // R3: sine reaches full scale at the quarter position and zero at three quarters
    assert_sine_peak_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.sel == SHAPE_SINE && int'(st_q.addr) == QUARTER) |-> (sample_o == 8'd255));
    assert_sine_trough_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.sel == SHAPE_SINE && int'(st_q.addr) == 3 * QUARTER) |-> (sample_o == 8'd0));

    // R4: triangle samples are multiples of eight
    assert_tri_step_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.sel == SHAPE_TRI) |-> (sample_o[2:0] == 3'b000));

    // R5: square only takes the two rail values
    assert_square_rails_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.sel == SHAPE_SQUARE) |-> (sample_o == 8'd0 || sample_o == 8'd255));

    // R6: sawtooth samples are multiples of four
    assert_saw_step_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.sel == SHAPE_SAW) |-> (sample_o[1:0] == 2'b00));

endmodule

// File: rtl/sig_gen_top.sv
module sig_gen_top
    import wavegen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] wave_sel,
    output logic [7:0]       sample
);

    phase_t  phase;
    sample_t tbl_out;

    wg_phase_counter #(
        .PW (PHASE_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase)
    );

    wg_wave_table #(
        .PW (PHASE_W),
        .NS (NUM_SHAPES)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase),
        .sel_i    (shape_e'(wave_sel)),
        .sample_o (tbl_out)
    );

    assign sample = tbl_out;

    // R8: a reset edge leaves the phase counter at zero
    assert_reset_phase_R8: assert property (@(posedge clk)
        rst |=> (phase == '0 || rst));

    // R7: a select change does not break the phase sequence
    assert_sel_keeps_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(wave_sel) && phase != {PHASE_W{1'b1}}) |=> (phase > $past(phase)));

endmodule

// File: tb/sig_gen_top_tb.sv
module sig_gen_top_tb;

    logic       clk;
    logic       rst;
    logic [1:0] sel;
    logic [7:0] sample;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    int m_cnt  = 0;
    int m_addr = 0;
    int m_sel  = 0;

    sig_gen_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .wave_sel (sel),
        .sample   (sample)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int ref_sample(input int s, input int n);
        real v;
        case (s)
            0: begin
                v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * n / 64.0);
                return $rtoi(v + 0.5);
            end
            1: return (n < 32) ? 8 * n : 8 * (63 - n);
            2: return (n < 32) ? 255 : 0;
            default: return 4 * n;
        endcase
    endfunction

    task automatic check(input int exp, input string tag);
        n_checks++;
        if (int'(sample) != exp) begin
            n_bad++;
            $display("FAIL %s: sel=%0d entry=%0d got=%0d exp=%0d",
                     tag, m_sel, m_addr, sample, exp);
        end
    endtask

    // One clock: update the requirement model, then sample away from the edge.
    task automatic tick(input string tag);
        @(posedge clk);
        if (rst) begin
            m_cnt  = 0;
            m_addr = 0;
        end else begin
            m_addr = m_cnt;
            m_cnt  = (m_cnt + 1) % 64;
        end
        m_sel = int'(sel);
        #2;
        check(ref_sample(m_sel, m_addr), tag);
    endtask

    initial begin
        rst = 1'b1;
        sel = 2'd0;
        // R8: reset holds sine entry 0
        repeat (3) tick("R8");
        sel = 2'd3;
        tick("R8");
        rst = 1'b0;
        // R2: entry 0 persists one more edge, then entry 1
        tick("R2");
        tick("R2");
        // R1: two full sawtooth periods
        repeat (128) tick("R1");
        sel = 2'd0;
        repeat (66) tick("R3");
        sel = 2'd1;
        repeat (66) tick("R4");
        sel = 2'd2;
        repeat (66) tick("R5");
        sel = 2'd3;
        repeat (66) tick("R6");
        // R7: select moves every clock
        for (int i = 0; i < 200; i++) begin
            sel = 2'((i * 3 + i / 5) % 4);
            tick("R7");
        end
        // R8: reset and select change on the same edge
        sel = 2'd1;
        rst = 1'b1;
        tick("R8");
        rst = 1'b0;
        sel = 2'd0;
        tick("R2");
        repeat (70) tick("R7");
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule